// File: doc/BRIEF.md
# Framed Reed-Solomon Systematic Encoder

This block is a streaming forward-error-correction encoder for a shortened Reed-Solomon code over 8-bit symbols. It takes in a packet of 188 data bytes, one byte per enabled clock. It sends the bytes out unchanged. Right after the last data byte it appends 16 check bytes, so each output codeword is 204 bytes long. With 16 check bytes, a matching decoder can repair up to 8 corrupted symbols in a codeword.

A single-cycle start pulse, high on the first data byte, frames each packet. No other framing input exists. A clock enable gates all progress. While the check bytes are being shifted out, the input bus is not read. The upstream source must therefore leave at least 16 cycles between packets. A start pulse that arrives before the current codeword is complete abandons that codeword and opens a new one.

The check bytes come from a 16-stage shift register of 8-bit stages. Each stage is updated through constant multipliers. The multiplier constants are derived at elaboration time from the generator polynomial.

Top module: `rs_frame_enc`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `sym_out_vld` and `parity_flag` are 0.
- R2: A byte accepted at a rising edge appears on `sym_out` from that edge onward. It is shown with `sym_out_vld`=1 and `parity_flag`=0 during the next enabled cycle. A byte is accepted when `en`=1 and either `frame_start`=1 or fewer than 188 bytes of the current packet have been taken.
- R3: In the 16 enabled cycles that follow the 188th data byte on the output, `sym_out` carries the 16 check bytes with `parity_flag`=1. The check bytes are the remainder of (data polynomial · x^16) divided by the generator. They are sent highest degree first. The first data byte is the highest-degree data coefficient.
- R4: Field arithmetic is GF(2^8) with reduction polynomial 0x11D. The generator is the product of (x + 2^i) for i = 0..15. Every output codeword therefore evaluates to zero at 2^0..2^15, so up to 8 symbol errors can be corrected.
- R5: When no codeword is in progress, input bytes without `frame_start` are ignored, and `sym_out_vld` stays 0.
- R6: Bytes presented without `frame_start` during the 16 check-byte cycles are not absorbed, and the check bytes are unchanged.
- R7: While `en`=0, all state holds, and `sym_out_vld` and `parity_flag` read 0. When `en` returns, the codeword continues exactly where it stopped.
- R8: `frame_start` in the middle of a codeword restarts framing. The check bytes then cover only the bytes from the new start onward.
- R9: A new `frame_start` in the first cycle after the 16th check cycle gives codewords that follow each other on the output with no idle cycle.
- R10: After the 16th check byte, if no new start arrives, `sym_out_vld` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; all progress stops while low |
| frame_start | input | 1 | High with the first data byte of a packet |
| sym_in | input | 8 | Data byte in |
| sym_out | output | 8 | Codeword byte out (data, then check bytes) |
| sym_out_vld | output | 1 | `sym_out` holds a codeword byte this cycle |
| parity_flag | output | 1 | `sym_out` holds a check byte this cycle |

## Verification
The embedded properties assume that `frame_start` is high only on the first byte of a packet. They also assume that the source respects the 16-cycle quiet period, except where a restart is meant. The directed stimulus drives `frame_start` for exactly one accepted cycle per packet. It puts idle or garbage bytes into the check-byte window, and it deliberately breaks framing only in the restart scenario. Enable stalls are placed both inside the data phase and inside the check-byte window, so the hold behaviour is exercised in both phases.

// File: rtl/rs_enc_pkg.sv
// Package: shared symbol width, field arithmetic and framing phase type
// for the framed Reed-Solomon encoder. Assumes a binary extension field
// GF(2^SYM_W) with primitive element 2.
package rs_enc_pkg;

    localparam int unsigned SYM_W = 8;
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAR  = 2'd2
    } phase_t;

    // Multiply two field elements (shift-and-add with modular reduction).
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    // Coefficient idx (low-degree first) of prod_{i<npar} (x + 2^i).
    function automatic logic [SYM_W-1:0] gen_coef(input int npar, input int idx);
        logic [SYM_W-1:0] g [0:64];
        logic [SYM_W-1:0] root;
        for (int j = 0; j <= 64; j++) g[j] = '0;
        g[0] = 1;
        root = 1;
        for (int i = 0; i < npar; i++) begin
            for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, 2);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Constant GF multiplier: p = a * COEF. Pure combinational; the constant
// is fixed at elaboration so the XOR network reduces to a few gates.
module rs_gf_cmul
    import rs_enc_pkg::*;
#(
    parameter logic [SYM_W-1:0] COEF = 1
) (
    input  logic [SYM_W-1:0] a,
    output logic [SYM_W-1:0] p
);

    // Product by the fixed coefficient.
    assign p = gf_mul(a, COEF);

endmodule

// File: rtl/rs_parity_lfsr.sv
// Parity shift register: NPAR stages of SYM_W bits dividing the message
// by the generator polynomial. clr zeroes the state in the same cycle it
// absorbs din; shift moves the remainder up one stage with zero feedback.
// Assumes clr only with absorb, and never absorb with shift.
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int unsigned NPAR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             absorb,
    input  logic             shift,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] top
);

    logic [SYM_W-1:0] r    [NPAR];
    logic [SYM_W-1:0] low  [NPAR];
    logic [SYM_W-1:0] prod [NPAR];
    logic [SYM_W-1:0] nxt  [NPAR];
    logic [SYM_W-1:0] fb;

    // Feedback symbol: input plus top stage (top treated as zero on clear).
    always_comb begin
        fb = '0;
        if (absorb) fb = din ^ (clr ? '0 : r[NPAR-1]);
    end

    for (genvar s = 0; s < NPAR; s++) begin : g_stage
        localparam logic [SYM_W-1:0] COEF_S = gen_coef(NPAR, s);

        rs_gf_cmul #(.COEF(COEF_S)) u_mul (
            .a (fb),
            .p (prod[s])
        );

        if (s == 0) begin : g_bottom
            assign low[s] = '0;
        end else begin : g_upper
            assign low[s] = clr ? '0 : r[s-1];
        end

        assign nxt[s] = low[s] ^ prod[s];
    end

    // State update on absorb or shift; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAR; i++) r[i] <= '0;
        end else if (absorb || shift) begin
            for (int i = 0; i < NPAR; i++) r[i] <= nxt[i];
        end
    end

    assign top = r[NPAR-1];

    // R3
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !absorb) |=> (r[NPAR-1] == $past(r[NPAR-2])));

    // R3
    clear_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && din == '0) |=> (r[0] == '0));

endmodule

// File: rtl/rs_frame_ctrl.sv
// Framing controller: tracks data and check phases of the codeword and
// issues absorb / clear / shift strobes. A start pulse always wins and
// restarts the count. Assumes K_DATA > NPAR >= 2.
module rs_frame_ctrl
    import rs_enc_pkg::*;
#(
    parameter int unsigned K_DATA = 188,
    parameter int unsigned NPAR   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    output logic acc,
    output logic clr,
    output logic shift,
    output logic last_acc
);

    localparam int unsigned CNT_W = $clog2(K_DATA);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(K_DATA - 1);
    localparam logic [CNT_W-1:0] PAR_LAST  = CNT_W'(NPAR - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    // Strobes derived from phase, start and enable.
    always_comb begin
        acc      = en && (start || phase == PH_DATA);
        clr      = en && start;
        shift    = en && !start && phase == PH_PAR;
        last_acc = en && !start && phase == PH_DATA && cnt == DATA_LAST;
    end

    // Phase and counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (en) begin
            if (start) begin
                phase <= PH_DATA;
                cnt   <= CNT_W'(1);
            end else begin
                unique case (phase)
                    PH_DATA: begin
                        if (cnt == DATA_LAST) begin
                            phase <= PH_PAR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_PAR: begin
                        if (cnt == PAR_LAST) begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // R2
    data_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (cnt != '0 && cnt <= DATA_LAST));

    // R3
    par_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAR) |-> (cnt <= PAR_LAST));

    // R10
    par_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAR && cnt == PAR_LAST && en && !start) |=> (phase == PH_IDLE));

endmodule

// File: rtl/rs_frame_enc.sv
// Top: framed systematic Reed-Solomon encoder. Data bytes pass through a
// registered output stage; after the last one the parity register is
// shifted out. Valid and parity flags are gated by the enable so each
// byte is presented in exactly one enabled cycle.
// Assumes one start pulse per packet and a 16-cycle gap between packets.
module rs_frame_enc
    import rs_enc_pkg::*;
#(
    parameter int unsigned K_DATA = 188,
    parameter int unsigned NPAR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_start,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_out_vld,
    output logic             parity_flag
);

    logic             acc, clr, shift, last_acc;
    logic [SYM_W-1:0] par_top;
    logic [SYM_W-1:0] dout_r;
    logic             vld_r, par_r;

    rs_frame_ctrl #(.K_DATA(K_DATA), .NPAR(NPAR)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .start    (frame_start),
        .acc      (acc),
        .clr      (clr),
        .shift    (shift),
        .last_acc (last_acc)
    );

    rs_parity_lfsr #(.NPAR(NPAR)) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .absorb (acc),
        .shift  (shift),
        .din    (sym_in),
        .top    (par_top)
    );

    // Output register: pass data, then emit check bytes, else go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_r <= '0;
            vld_r  <= 1'b0;
            par_r  <= 1'b0;
        end else if (en) begin
            if (acc) begin
                dout_r <= sym_in;
                vld_r  <= 1'b1;
                par_r  <= 1'b0;
            end else if (shift) begin
                dout_r <= par_top;
                vld_r  <= 1'b1;
                par_r  <= 1'b1;
            end else begin
                vld_r  <= 1'b0;
                par_r  <= 1'b0;
            end
        end
    end

    assign sym_out     = dout_r;
    assign sym_out_vld = vld_r & en;
    assign parity_flag = par_r & en;

    // R2
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (dout_r == $past(sym_in) && vld_r && !par_r));

    // R3
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_acc |=> (vld_r && !par_r) ##1 (!en || (par_r || $past(frame_start))));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout_r) && $stable(vld_r) && $stable(par_r)));

    // R10
    par_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_r |-> vld_r);

endmodule

// File: tb/sim_rs_frame_enc.sv
// Directed bench for rs_frame_enc with a software division model.
module sim_rs_frame_enc;

    localparam int CLK_P = 10;
    localparam int KD    = 188;
    localparam int NP    = 16;
    localparam int NW    = KD + NP;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] sym_in = '0;
    logic [7:0] sym_out;
    logic       sym_out_vld;
    logic       parity_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int hold_viol = 0;

    logic [7:0] cap_d [$];
    logic       cap_p [$];
    int         cap_c [$];
    logic [7:0] exp_d [$];
    logic       exp_p [$];

    logic [7:0] dat [0:KD-1];
    logic [7:0] par [0:NP-1];
    logic [7:0] gh  [0:NP];

    rs_frame_enc u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .frame_start (frame_start),
        .sym_in      (sym_in),
        .sym_out     (sym_out),
        .sym_out_vld (sym_out_vld),
        .parity_flag (parity_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Capture output bytes mid-cycle.
    always @(negedge clk) begin
        if (rst_n && sym_out_vld) begin
            cap_d.push_back(sym_out);
            cap_p.push_back(parity_flag);
            cap_c.push_back(cyc);
        end
        if (!en && (sym_out_vld || parity_flag)) hold_viol++;
    end

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Generator, highest degree first.
    task automatic build_gen();
        logic [7:0] gl [0:NP];
        logic [7:0] root = 1;
        for (int j = 0; j <= NP; j++) gl[j] = 0;
        gl[0] = 1;
        for (int i = 0; i < NP; i++) begin
            for (int j = i + 1; j >= 1; j--) gl[j] = gl[j-1] ^ gm(gl[j], root);
            gl[0] = gm(gl[0], root);
            root = gm(root, 8'h02);
        end
        for (int j = 0; j <= NP; j++) gh[j] = gl[NP-j];
    endtask

    // Long division of dat * x^16 by the generator; queue expected word.
    task automatic push_expected();
        logic [7:0] w [0:NW-1];
        for (int i = 0; i < NW; i++) w[i] = (i < KD) ? dat[i] : 8'h00;
        for (int i = 0; i < KD; i++) begin
            logic [7:0] c = w[i];
            for (int j = 0; j <= NP; j++) w[i+j] ^= gm(gh[j], c);
        end
        for (int k = 0; k < NP; k++) par[k] = w[KD+k];
        for (int i = 0; i < KD; i++) begin exp_d.push_back(dat[i]); exp_p.push_back(1'b0); end
        for (int k = 0; k < NP; k++) begin exp_d.push_back(par[k]); exp_p.push_back(1'b1); end
    endtask

    task automatic step(input logic e, input logic s, input logic [7:0] d);
        @(posedge clk);
        #1;
        en = e; frame_start = s; sym_in = d;
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h3C ^ 8'(i));
    endtask

    task automatic clear_all();
        cap_d.delete(); cap_p.delete(); cap_c.delete();
        exp_d.delete(); exp_p.delete();
    endtask

    // Feed dat as one packet plus a 16-cycle garbage window; optional stalls.
    task automatic feed_packet(input bit stall);
        for (int i = 0; i < KD; i++) begin
            if (stall && (i % 29) == 5) begin step(1'b0, 1'b0, 8'hEE); step(1'b0, 1'b1, 8'hEF); end
            step(1'b1, i == 0, dat[i]);
        end
        for (int p = 0; p < NP; p++) begin
            if (stall && p == 7) begin step(1'b0, 1'b1, 8'h11); step(1'b0, 1'b0, 8'h22); end
            step(1'b1, 1'b0, 8'hA5 ^ 8'(p * 13));
        end
    endtask

    task automatic compare(input string req, input string req_p);
        chk(cap_d.size() == exp_d.size(), req, "byte count", cap_d.size(), exp_d.size());
        for (int i = 0; i < exp_d.size() && i < cap_d.size(); i++) begin
            chk(cap_d[i] == exp_d[i], exp_p[i] ? req_p : req, $sformatf("byte %0d", i),
                cap_d[i], exp_d[i]);
            chk(cap_p[i] == exp_p[i], req_p, $sformatf("parity flag %0d", i), cap_p[i], exp_p[i]);
        end
    endtask

    // R4: syndromes of a captured codeword at 2^0..2^15 must be zero.
    task automatic check_syndromes(input int base);
        logic [7:0] root = 1;
        for (int r = 0; r < NP; r++) begin
            logic [7:0] s = 0;
            for (int k = 0; k < NW; k++) s = gm(s, root) ^ cap_d[base+k];
            chk(s == 0, "R4", $sformatf("syndrome %0d", r), s, 0);
            root = gm(root, 8'h02);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sym_out_vld == 1'b0, "R1", "valid in reset", sym_out_vld, 0);
        chk(parity_flag == 1'b0, "R1", "parity flag in reset", parity_flag, 0);
        step(1'b1, 1'b0, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(sym_out_vld == 1'b0, "R1", "valid after release", sym_out_vld, 0);
        chk(parity_flag == 1'b0, "R1", "parity flag after release", parity_flag, 0);
    endtask

    task automatic t_idle_ignore();
        clear_all();
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 8'(i * 17 + 1));
        flush(3);
        chk(cap_d.size() == 0, "R5", "bytes out without start", cap_d.size(), 0);
    endtask

    task automatic t_basic();
        clear_all();
        for (int i = 0; i < KD; i++) dat[i] = 8'(i + 1);
        push_expected();
        feed_packet(1'b0);
        flush(20);
        compare("R2", "R3");
        chk(cap_d.size() == NW, "R6", "garbage in check window absorbed", cap_d.size(), NW);
        chk(cap_d.size() == NW, "R10", "valid after codeword end", cap_d.size(), NW);
        if (cap_d.size() >= NW) check_syndromes(0);
    endtask

    task automatic t_stall();
        clear_all();
        hold_viol = 0;
        for (int i = 0; i < KD; i++) dat[i] = 8'(i * 7 + 3);
        push_expected();
        feed_packet(1'b1);
        flush(20);
        compare("R7", "R7");
        chk(hold_viol == 0, "R7", "valid seen while disabled", hold_viol, 0);
    endtask

    task automatic t_restart();
        clear_all();
        for (int i = 0; i < 50; i++) begin
            step(1'b1, i == 0, 8'(i * 3 + 9));
            exp_d.push_back(8'(i * 3 + 9)); exp_p.push_back(1'b0);
        end
        for (int i = 0; i < KD; i++) dat[i] = 8'(255 - i);
        push_expected();
        feed_packet(1'b0);
        flush(20);
        compare("R8", "R8");
        if (cap_d.size() >= 50 + NW) check_syndromes(50);
    endtask

    task automatic t_back_to_back();
        clear_all();
        for (int i = 0; i < KD; i++) dat[i] = 8'(i + 1) ^ 8'h5A;
        push_expected();
        feed_packet(1'b0);
        for (int i = 0; i < KD; i++) dat[i] = 8'(i * i);
        push_expected();
        feed_packet(1'b0);
        flush(20);
        compare("R9", "R9");
        if (cap_c.size() == 2 * NW)
            chk(cap_c[2*NW-1] - cap_c[0] + 1 == 2 * NW, "R9", "gap between codewords",
                cap_c[2*NW-1] - cap_c[0] + 1, 2 * NW);
        if (cap_d.size() >= 2 * NW) check_syndromes(NW);
    endtask

    initial begin
        build_gen();
        t_reset();
        t_idle_ignore();
        t_basic();
        t_stall();
        t_restart();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule